// File: doc/BRIEF.md
# Burst Address Counter Register

This block produces the address presented to one port of a synchronous memory. On every rising clock edge it picks one of four actions for its address register. It can clear the register to zero, capture an address supplied from outside, keep the address it used last, or step forward by one so that a burst can run without new addresses. The choice follows a fixed priority. A counter clear beats an address capture, and an address capture beats a step.

The block does not look at chip enables or at the read/write line when it updates the address. Captures and steps therefore take effect whether or not the port is selected. The read/write line feeds only a registered warning flag. That flag goes high for one cycle after an edge at which an address was being captured while a write was also requested. Holding read/write high during a capture is the safe way to load an address.

A synchronous power-up reset, separate from the counter-clear input, brings the register and the flag to zero. The memory array and any output data latency are outside this block.

Top module: `burst_addr_ctr`

## Requirements
- R1: While `rst` is high at a rising edge, `cur_addr` becomes 0 and `load_write_warn` becomes 0 after that edge, whatever the other inputs are.
- R2: With `rst` low, `cnt_rst_n` low at a rising edge makes `cur_addr` 0 after that edge, regardless of `strobe_n` and `cnt_en_n`.
- R3: With `rst` low and `cnt_rst_n` high, `strobe_n` low at a rising edge loads `ext_addr` into `cur_addr`, regardless of `cnt_en_n`.
- R4: With `rst` low and `cnt_rst_n`, `strobe_n` and `cnt_en_n` all high at a rising edge, `cur_addr` keeps its previous value and `ext_addr` has no effect.
- R5: With `rst` low, `cnt_rst_n` high, `strobe_n` high and `cnt_en_n` low at a rising edge, `cur_addr` becomes its previous value plus one.
- R6: A step from the all-ones address (2^AW-1) wraps `cur_addr` to 0.
- R7: `load_write_warn` is 1 during the cycle after a rising edge (with `rst` low) at which both `strobe_n` and `wr_n` were low, and 0 after any other edge.
- R8: `wr_n` has no effect on `cur_addr`: the same inputs with `wr_n` low or high give the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous power-up reset, active high |
| ext_addr | input | AW | Address offered for capture |
| strobe_n | input | 1 | Address capture request, active low |
| cnt_en_n | input | 1 | Step request, active low |
| cnt_rst_n | input | 1 | Counter clear, active low, highest priority after `rst` |
| wr_n | input | 1 | Read/write line, low means write; feeds only the warning |
| cur_addr | output | AW | Address used for the current access |
| load_write_warn | output | 1 | Registered flag: capture coincided with a write |

## Verification
Directed sequences set up each priority conflict on purpose: a clear together with a capture and a step, a capture together with a step, and a hold while `ext_addr` changes. These show whether the priority order is right and whether the held address leaks in from outside. A capture of the all-ones address followed by steps checks the wrap. Repeated patterns that differ only in `wr_n` show that the read/write line stays away from the address and reaches only the flag. A long stretch of seeded random control combinations, biased toward runs of steps, compares every cycle against a bench model. It catches off-by-one and stale-state errors that the directed cases could miss.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

   // Action taken by the address register at a clock edge, listed by priority
   typedef enum logic [1:0] {
      BAC_CLEAR = 2'd0,
      BAC_LOAD  = 2'd1,
      BAC_STEP  = 2'd2,
      BAC_KEEP  = 2'd3
   } bac_op_e;

   localparam int BAC_AW_MIN = 1;
   localparam int BAC_AW_MAX = 32;

endpackage

// File: rtl/bac_op_decode.sv
module bac_op_decode
   import burst_addr_pkg::*;
(
   input  logic    cnt_rst_n,
   input  logic    strobe_n,
   input  logic    cnt_en_n,
   output bac_op_e op
);

   always_comb begin
      if (!cnt_rst_n)     op = BAC_CLEAR;
      else if (!strobe_n) op = BAC_LOAD;
      else if (!cnt_en_n) op = BAC_STEP;
      else                op = BAC_KEEP;
   end

endmodule

// File: rtl/bac_next_addr.sv
module bac_next_addr
   import burst_addr_pkg::*;
#(
   parameter int AW = 17
) (
   input  bac_op_e         op,
   input  logic [AW-1:0]   cur,
   input  logic [AW-1:0]   ext,
   output logic [AW-1:0]   nxt
);

   localparam logic [AW-1:0] ONE = AW'(1);

   logic [AW-1:0] stepped;

   // Natural-width add: carry out of the top bit is dropped, giving wrap to zero
   assign stepped = cur + ONE;

   always_comb begin
      unique case (op)
         BAC_CLEAR: nxt = '0;
         BAC_LOAD:  nxt = ext;
         BAC_STEP:  nxt = stepped;
         default:   nxt = cur;
      endcase
   end

endmodule

// File: rtl/bac_warn_flag.sv
module bac_warn_flag (
   input  logic clk,
   input  logic rst,
   input  logic strobe_n,
   input  logic wr_n,
   output logic warn
);

   always_ff @(posedge clk) begin
      if (rst) warn <= 1'b0;
      else     warn <= ~strobe_n & ~wr_n;
   end

endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
   import burst_addr_pkg::*;
#(
   parameter int AW = 17
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] ext_addr,
   input  logic          strobe_n,
   input  logic          cnt_en_n,
   input  logic          cnt_rst_n,
   input  logic          wr_n,
   output logic [AW-1:0] cur_addr,
   output logic          load_write_warn
);

   generate
      if (AW < BAC_AW_MIN || AW > BAC_AW_MAX) begin : g_bad_aw
         $error("burst_addr_ctr: AW out of supported range");
      end
   endgenerate

   bac_op_e       op;
   logic [AW-1:0] addr_q;
   logic [AW-1:0] addr_d;

   bac_op_decode u_decode (
      .cnt_rst_n (cnt_rst_n),
      .strobe_n  (strobe_n),
      .cnt_en_n  (cnt_en_n),
      .op        (op)
   );

   bac_next_addr #(.AW(AW)) u_next (
      .op  (op),
      .cur (addr_q),
      .ext (ext_addr),
      .nxt (addr_d)
   );

   always_ff @(posedge clk) begin
      if (rst) addr_q <= '0;
      else     addr_q <= addr_d;
   end

   bac_warn_flag u_warn (
      .clk      (clk),
      .rst      (rst),
      .strobe_n (strobe_n),
      .wr_n     (wr_n),
      .warn     (load_write_warn)
   );

   assign cur_addr = addr_q;

endmodule

// File: rtl/burst_addr_ctr_checker.sv
module burst_addr_ctr_checker #(
   parameter int AW = 17
) (
   input logic          clk,
   input logic          rst,
   input logic [AW-1:0] ext_addr,
   input logic          strobe_n,
   input logic          cnt_en_n,
   input logic          cnt_rst_n,
   input logic          wr_n,
   input logic [AW-1:0] cur_addr,
   input logic          load_write_warn
);

   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (cur_addr == '0 && !load_write_warn));

   assert_clear_wins_R2: assert property (@(posedge clk) disable iff (rst)
      !cnt_rst_n |=> cur_addr == '0);

   assert_load_ext_R3: assert property (@(posedge clk) disable iff (rst)
      (cnt_rst_n && !strobe_n) |=> cur_addr == $past(ext_addr));

   assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (cnt_rst_n && strobe_n && cnt_en_n) |=> $stable(cur_addr));

   // covers R6 as well: the cast drops the carry so all-ones steps to zero
   assert_step_R5: assert property (@(posedge clk) disable iff (rst)
      (cnt_rst_n && strobe_n && !cnt_en_n) |=> cur_addr == AW'($past(cur_addr) + 1'b1));

   assert_warn_set_R7: assert property (@(posedge clk) disable iff (rst)
      (!strobe_n && !wr_n) |=> load_write_warn);

   assert_warn_clear_R7: assert property (@(posedge clk) disable iff (rst)
      !(!strobe_n && !wr_n) |=> !load_write_warn);

endmodule

bind burst_addr_ctr burst_addr_ctr_checker #(.AW(AW)) u_checker (
   .clk             (clk),
   .rst             (rst),
   .ext_addr        (ext_addr),
   .strobe_n        (strobe_n),
   .cnt_en_n        (cnt_en_n),
   .cnt_rst_n       (cnt_rst_n),
   .wr_n            (wr_n),
   .cur_addr        (cur_addr),
   .load_write_warn (load_write_warn)
);

// File: tb/tb_burst_addr_ctr.sv
module tb_burst_addr_ctr;
   localparam int AW = 17;
   localparam logic [AW-1:0] MAXA = '1;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst;
   logic [AW-1:0] ext_addr;
   logic          strobe_n, cnt_en_n, cnt_rst_n, wr_n;
   logic [AW-1:0] cur_addr;
   logic          load_write_warn;

   int vectors = 0;
   int miscompares = 0;
   bit done = 0;
   logic [AW-1:0] exp_addr = '0;
   logic          exp_warn = 1'b0;
   logic [AW-1:0] saved_addr;

   burst_addr_ctr #(.AW(AW)) dut (
      .clk(clk), .rst(rst), .ext_addr(ext_addr), .strobe_n(strobe_n),
      .cnt_en_n(cnt_en_n), .cnt_rst_n(cnt_rst_n), .wr_n(wr_n),
      .cur_addr(cur_addr), .load_write_warn(load_write_warn)
   );

   function automatic logic [AW-1:0] model_addr(input logic [AW-1:0] prev,
         input logic [AW-1:0] ext, input logic r, input logic crn,
         input logic sn, input logic en);
      if (r)        return '0;
      if (!crn)     return '0;
      if (!sn)      return ext;
      if (!en)      return prev + AW'(1);
      return prev;
   endfunction

   function automatic string addr_tag(input logic [AW-1:0] prev, input logic r,
         input logic crn, input logic sn, input logic en);
      if (r)        return "R1";
      if (!crn)     return "R2";
      if (!sn)      return "R3";
      if (en)       return "R4";
      if (prev == MAXA) return "R6";
      return "R5";
   endfunction

   task automatic apply(input logic r, input logic [AW-1:0] a, input logic sn,
         input logic en, input logic crn, input logic w, input string note);
      string tag;
      @(negedge clk);
      rst = r; ext_addr = a; strobe_n = sn; cnt_en_n = en; cnt_rst_n = crn; wr_n = w;
      @(posedge clk);
      tag = (note != "") ? note : addr_tag(exp_addr, r, crn, sn, en);
      exp_addr = model_addr(exp_addr, a, r, crn, sn, en);
      exp_warn = r ? 1'b0 : (!sn && !w);
      #2;
      vectors++;
      if (cur_addr !== exp_addr) begin
         miscompares++;
         $display("FAIL %s cur_addr actual=%h expected=%h", tag, cur_addr, exp_addr);
      end
      vectors++;
      if (load_write_warn !== exp_warn) begin
         miscompares++;
         $display("FAIL %s load_write_warn actual=%b expected=%b",
                  r ? "R1" : "R7", load_write_warn, exp_warn);
      end
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      rst = 1'b1; ext_addr = '0; strobe_n = 1'b1; cnt_en_n = 1'b1;
      cnt_rst_n = 1'b1; wr_n = 1'b1;
      // R1 reset state
      apply(1, 17'h1abcd, 0, 0, 1, 0, "R1");
      apply(0, 17'h00123, 0, 1, 1, 1, "R3");
      // R4 hold with a changing external address
      apply(0, 17'h1ffff, 1, 1, 1, 1, "R4");
      apply(0, 17'h05555, 1, 1, 1, 1, "R4");
      // R5 burst steps
      for (int i = 0; i < 4; i++) apply(0, 17'h0aaaa, 1, 0, 1, 1, "R5");
      // R3 capture beats step
      apply(0, 17'h00f00, 0, 0, 1, 1, "R3");
      // R2 clear beats capture and step
      apply(0, 17'h12345, 0, 0, 0, 1, "R2");
      // R6 wrap from all ones
      apply(0, MAXA, 0, 1, 1, 1, "R3");
      apply(0, 17'h00001, 1, 0, 1, 1, "R6");
      apply(0, 17'h00001, 1, 0, 1, 1, "R5");
      // R7 warning: capture with write, then capture with read
      apply(0, 17'h00777, 0, 1, 1, 0, "R7");
      apply(0, 17'h00778, 0, 1, 1, 1, "R7");
      apply(0, 17'h00779, 1, 1, 1, 0, "R7");
      // R8: same step with wr_n low and high lands on consecutive addresses
      saved_addr = exp_addr;
      apply(0, 17'h00000, 1, 0, 1, 0, "R8");
      apply(0, 17'h00000, 1, 0, 1, 1, "R8");
      vectors++;
      if (cur_addr !== saved_addr + AW'(2)) begin
         miscompares++;
         $display("FAIL R8 cur_addr actual=%h expected=%h", cur_addr, saved_addr + AW'(2));
      end
      // R1 from a non-zero state
      apply(1, 17'h0abcd, 0, 0, 1, 0, "R1");
      // random stretch, steps favoured
      for (int i = 0; i < 3000; i++) begin
         logic [AW-1:0] ra;
         logic rsn, ren, rcr, rw, rr;
         ra  = AW'($urandom);
         if (($urandom % 5) == 0) ra = MAXA;
         rsn = ($urandom % 4) != 0;
         ren = ($urandom % 3) == 0;
         rcr = ($urandom % 16) != 0;
         rw  = ($urandom % 2) == 0;
         rr  = ($urandom % 200) == 0;
         apply(rr, ra, rsn, ren, rcr, rw, "");
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog run did not finish actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule